// File: doc/BRIEF.md
# Scaled-Index Shift-and-Add Unit

This is a 64-bit integer execution unit. It forms the sum of a base operand and an index operand that has been scaled by a power of two. It serves address arithmetic in hot loops: a pointer plus an element index times 2, 4, 8 or 16. It also serves ordinary multiply-accumulate by small powers of two. The index can be the whole 64-bit operand, or the low 32 bits of it. When only the low 32 bits are used, they are either zero-extended or sign-extended, so that both `unsigned` and `int` style array subscripts are covered.

A request is presented with a valid strobe. The result appears registered on the next clock edge. A record bit asks the unit to also produce a 4-bit condition field. That field classifies the signed result and carries a sticky summary-overflow bit supplied from outside. An undefined operation code gives an error pulse instead of a result.

Top module: `scaled_add_unit`

## Requirements
- R1: The index is shifted left by `in_sh + 1`. The values 0, 1, 2 and 3 of `in_sh` therefore scale by 2, 4, 8 and 16, and the index is never used unscaled. For example, base 0x100, index 2 and `in_sh`=3 give 0x120.
- R2: With `in_op`=2'b00 (full width), the result is `in_base + (in_index << (in_sh+1))` on unsigned 64-bit values.
- R3: With `in_op`=2'b01 (unsigned word), only `in_index[31:0]` is used. It is zero-extended to 64 bits before scaling, and `in_index[63:32]` has no effect on the result.
- R4: With `in_op`=2'b10 (signed word), `in_index[31:0]` is sign-extended to 64 bits before scaling. A negative word therefore subtracts from the base, and `in_index[63:32]` has no effect.
- R5: Bits shifted above bit 63 and the carry out of the add are dropped, so the result wraps modulo 2^64.
- R6: For a legal operation, `out_valid`, `out_result` and `out_cond_we` are updated on the first clock edge after `in_valid` is sampled high. On a cycle in which `in_valid` is low, `out_valid` and `out_err` are low one edge later.
- R7: When `in_rec`=1 on a legal operation, `out_cond_we` is 1 and `out_cond` is {negative, positive, zero, summary-overflow}. Bit 3 is set when the signed result is below zero, bit 2 when it is above zero, bit 1 when it equals zero, and bit 0 copies `in_so`.
- R8: When `in_rec`=0 on a legal operation, `out_cond_we` is 0.
- R9: `in_op`=2'b11 is illegal. One edge later `out_err` is 1 and both `out_valid` and `out_cond_we` are 0, and `out_result` keeps its previous value.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_err`, `out_cond_we`, `out_result` and `out_cond` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation: 00 full, 01 unsigned word, 10 signed word, 11 illegal |
| in_sh | input | 2 | Scale field; shift amount is this value plus one |
| in_rec | input | 1 | Request a condition field |
| in_base | input | 64 | Base operand |
| in_index | input | 64 | Index operand |
| in_so | input | 1 | Sticky summary-overflow copied into the condition field |
| out_valid | output | 1 | Result is valid |
| out_result | output | 64 | Registered sum |
| out_cond | output | 4 | Condition field {neg, pos, zero, so} |
| out_cond_we | output | 1 | Condition field is written this cycle |
| out_err | output | 1 | Illegal operation was requested |

## Verification
Two functions can coincide in one cycle: modular wrap-around and condition generation. The condition flags must describe the wrapped 64-bit value, not the mathematical sum. Directed cases pick a base equal to the two's-complement negation of the scaled index, so the add overflows to exactly zero with the record bit set. Other cases use signed-word indices whose sign extension carries into bit 63. The bench judges the zero, negative and positive bits against a model that truncates before classifying. The constrained-random phase mixes all four operation codes with random record bits to hit the same overlap repeatedly.

// File: rtl/sa_pkg.sv
package sa_pkg;

   typedef enum logic [1:0] {
      SA_OP_FULL  = 2'b00,
      SA_OP_UWORD = 2'b01,
      SA_OP_SWORD = 2'b10,
      SA_OP_BAD   = 2'b11
   } sa_op_e;

   // bit positions inside the condition field
   localparam int unsigned CND_NEG  = 3;
   localparam int unsigned CND_POS  = 2;
   localparam int unsigned CND_ZERO = 1;
   localparam int unsigned CND_SO   = 0;
   localparam int unsigned CND_W    = 4;

endpackage

// File: rtl/sa_index_ext.sv
module sa_index_ext
   import sa_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned WORD_W = 32
) (
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] idx,
   output logic [DATA_W-1:0] ext
);

   localparam int unsigned PAD_W = DATA_W - WORD_W;

   logic [WORD_W-1:0] low_word;
   logic              sign_bit;

   assign low_word = idx[WORD_W-1:0];
   assign sign_bit = low_word[WORD_W-1];

   generate
      if (PAD_W == 0) begin : g_same_width
         always_comb ext = idx;
      end else begin : g_narrow_word
         always_comb begin
            unique case (sa_op_e'(op))
               SA_OP_UWORD: ext = {{PAD_W{1'b0}}, low_word};
               SA_OP_SWORD: ext = {{PAD_W{sign_bit}}, low_word};
               default:     ext = idx;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/sa_scaler.sv
module sa_scaler #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned SH_W   = 2,
   parameter bit          BARREL = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   sh,
   output logic [DATA_W-1:0] dout
);

   // the minimum scale of two is a fixed wire shift
   logic [DATA_W-1:0] pre;
   assign pre = {din[DATA_W-2:0], 1'b0};

   generate
      if (BARREL) begin : g_log_stages
         logic [DATA_W-1:0] stg [0:SH_W];
         assign stg[0] = pre;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            assign stg[k+1] = sh[k] ? (stg[k] << (1 << k)) : stg[k];
         end
         assign dout = stg[SH_W];
      end else begin : g_var_shift
         assign dout = pre << sh;
      end
   endgenerate

endmodule

// File: rtl/sa_cond_gen.sv
module sa_cond_gen
   import sa_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic [DATA_W-1:0] res,
   input  logic              so,
   output logic [CND_W-1:0]  cond
);

   logic is_neg;
   logic is_zero;

   assign is_neg  = res[DATA_W-1];
   assign is_zero = ~|res;

   always_comb begin
      cond           = '0;
      cond[CND_NEG]  = is_neg;
      cond[CND_POS]  = ~is_neg & ~is_zero;
      cond[CND_ZERO] = is_zero;
      cond[CND_SO]   = so;
   end

endmodule

// File: rtl/scaled_add_unit.sv
module scaled_add_unit
   import sa_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned SH_W   = 2,
   parameter bit          BARREL = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [1:0]        in_op,
   input  logic [SH_W-1:0]   in_sh,
   input  logic              in_rec,
   input  logic [DATA_W-1:0] in_base,
   input  logic [DATA_W-1:0] in_index,
   input  logic              in_so,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic [CND_W-1:0]  out_cond,
   output logic              out_cond_we,
   output logic              out_err
);

   generate
      if (WORD_W > DATA_W) begin : g_bad_word
         $error("scaled_add_unit: WORD_W must not exceed DATA_W");
      end
      if (SH_W < 1 || (1 << SH_W) >= DATA_W) begin : g_bad_sh
         $error("scaled_add_unit: SH_W out of range for DATA_W");
      end
   endgenerate

   logic              op_ok;
   logic              take;
   logic [DATA_W-1:0] idx_ext;
   logic [DATA_W-1:0] idx_scaled;
   logic [DATA_W-1:0] sum;
   logic [CND_W-1:0]  cond_nxt;

   assign op_ok = (sa_op_e'(in_op) != SA_OP_BAD);
   assign take  = in_valid & op_ok;

   sa_index_ext #(
      .DATA_W (DATA_W),
      .WORD_W (WORD_W)
   ) u_ext (
      .op  (in_op),
      .idx (in_index),
      .ext (idx_ext)
   );

   sa_scaler #(
      .DATA_W (DATA_W),
      .SH_W   (SH_W),
      .BARREL (BARREL)
   ) u_scale (
      .din  (idx_ext),
      .sh   (in_sh),
      .dout (idx_scaled)
   );

   // carry out is dropped: modular sum
   assign sum = in_base + idx_scaled;

   sa_cond_gen #(
      .DATA_W (DATA_W)
   ) u_cond (
      .res  (sum),
      .so   (in_so),
      .cond (cond_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_err     <= 1'b0;
         out_cond_we <= 1'b0;
         out_result  <= '0;
         out_cond    <= '0;
      end else begin
         out_valid   <= take;
         out_err     <= in_valid & ~op_ok;
         out_cond_we <= take & in_rec;
         if (take) begin
            out_result <= sum;
            if (in_rec) begin
               out_cond <= cond_nxt;
            end
         end
      end
   end

endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned SH_W   = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [1:0]        in_op,
   input logic [SH_W-1:0]   in_sh,
   input logic              in_rec,
   input logic [DATA_W-1:0] in_base,
   input logic [DATA_W-1:0] in_index,
   input logic              in_so,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_result,
   input logic [3:0]        out_cond,
   input logic              out_cond_we,
   input logic              out_err
);

   localparam int unsigned PAD_W = DATA_W - WORD_W;

   logic [DATA_W-1:0] sx_index;
   assign sx_index = {{PAD_W{in_index[WORD_W-1]}}, in_index[WORD_W-1:0]};

   // R10
   rst_clears_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && !out_err && !out_cond_we && out_result == '0));

   // R6
   legal_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op != 2'b11) |=> out_valid);

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !out_err));

   // R2
   full_sum_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == 2'b00) |=>
         out_result == $past(in_base) + ($past(in_index) << ({1'b0, $past(in_sh)} + 1)));

   // R4
   sword_sum_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == 2'b10) |=>
         out_result == $past(in_base) + ($past(sx_index) << ({1'b0, $past(in_sh)} + 1)));

   // R7
   cond_shape_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op != 2'b11 && in_rec) |=>
         (out_cond_we && $countones(out_cond[3:1]) == 1
          && out_cond[0] == $past(in_so)
          && out_cond[1] == (out_result == '0)));

   // R8
   no_rec_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_rec) |=> !out_cond_we);

   // R9
   illegal_op_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op == 2'b11) |=>
         (out_err && !out_valid && !out_cond_we && $stable(out_result)));

endmodule

bind scaled_add_unit sa_checker #(
   .DATA_W (DATA_W),
   .WORD_W (WORD_W),
   .SH_W   (SH_W)
) u_sa_checker (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .in_op       (in_op),
   .in_sh       (in_sh),
   .in_rec      (in_rec),
   .in_base     (in_base),
   .in_index    (in_index),
   .in_so       (in_so),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_cond    (out_cond),
   .out_cond_we (out_cond_we),
   .out_err     (out_err)
);

// File: tb/scaled_add_unit_bench.sv
`timescale 1ns/1ps
module scaled_add_unit_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [1:0]  in_op;
   logic [1:0]  in_sh;
   logic        in_rec;
   logic [63:0] in_base;
   logic [63:0] in_index;
   logic        in_so;
   logic        out_valid;
   logic [63:0] out_result;
   logic [3:0]  out_cond;
   logic        out_cond_we;
   logic        out_err;

   int checks   = 0;
   int failures = 0;
   logic [63:0] last_res;

   always #2 clk = ~clk;

   scaled_add_unit u_scaled_add_unit (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .in_op       (in_op),
      .in_sh       (in_sh),
      .in_rec      (in_rec),
      .in_base     (in_base),
      .in_index    (in_index),
      .in_so       (in_so),
      .out_valid   (out_valid),
      .out_result  (out_result),
      .out_cond    (out_cond),
      .out_cond_we (out_cond_we),
      .out_err     (out_err)
   );

   function automatic logic [63:0] model_sum(input logic [1:0] op, input logic [1:0] sh,
                                             input logic [63:0] b, input logic [63:0] x);
      logic [63:0] e;
      case (op)
         2'b01:   e = {32'h0, x[31:0]};
         2'b10:   e = {{32{x[31]}}, x[31:0]};
         default: e = x;
      endcase
      return b + (e << (int'(sh) + 1));
   endfunction

   function automatic logic [3:0] model_cond(input logic [63:0] r, input logic so);
      logic n, z;
      n = r[63];
      z = (r == 64'h0);
      return {n, !n && !z, z, so};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one request, then one idle cycle; samples at falling edges
   task automatic run(input string tag, input logic [1:0] op, input logic [1:0] sh,
                      input logic rec, input logic [63:0] b, input logic [63:0] x,
                      input logic so);
      logic [63:0] er;
      logic [3:0]  ec;
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_sh = sh; in_rec = rec;
      in_base = b; in_index = x; in_so = so;
      @(negedge clk);
      in_valid = 1'b0;
      if (op == 2'b11) begin
         chk(out_err == 1'b1, {tag, " R9 err"}, 64'(out_err), 64'd1);
         chk(out_valid == 1'b0 && out_cond_we == 1'b0, {tag, " R9 no write"},
             64'({out_valid, out_cond_we}), 64'd0);
         chk(out_result == last_res, {tag, " R9 result held"}, out_result, last_res);
      end else begin
         er = model_sum(op, sh, b, x);
         ec = model_cond(er, so);
         chk(out_valid == 1'b1 && out_err == 1'b0, {tag, " R6 valid"},
             64'({out_valid, out_err}), 64'd2);
         chk(out_result == er, tag, out_result, er);
         chk(out_cond_we == rec, {tag, rec ? " R7 we" : " R8 we"}, 64'(out_cond_we), 64'(rec));
         if (rec) chk(out_cond == ec, {tag, " R7 cond"}, 64'(out_cond), 64'(ec));
         last_res = er;
      end
      @(negedge clk);
      chk(out_valid == 1'b0 && out_err == 1'b0, {tag, " R6 idle"},
          64'({out_valid, out_err}), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_op = 2'b00; in_sh = 2'b00; in_rec = 1'b0;
      in_base = '0; in_index = '0; in_so = 1'b0;
      last_res = '0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(out_valid == 1'b0 && out_err == 1'b0 && out_cond_we == 1'b0, "R10 flags",
          64'({out_valid, out_err, out_cond_we}), 64'd0);
      chk(out_result == '0 && out_cond == '0, "R10 data", out_result, 64'd0);
      // R10: a request during reset changes nothing
      in_valid = 1'b1; in_base = 64'h55; in_rec = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0 && out_result == '0, "R10 held in reset", out_result, 64'd0);
      in_valid = 1'b0; rst = 1'b0;
      @(negedge clk);

      // R1 scale by 2,4,8,16
      run("R1 sh0", 2'b00, 2'd0, 1'b1, 64'h1000, 64'h1, 1'b0);
      run("R1 sh1", 2'b00, 2'd1, 1'b0, 64'h1000, 64'h1, 1'b0);
      run("R1 sh2", 2'b00, 2'd2, 1'b1, 64'h1000, 64'h1, 1'b1);
      run("R1 sh3", 2'b00, 2'd3, 1'b1, 64'h100, 64'h2, 1'b0);
      // R2 full width uses the upper half
      run("R2 full", 2'b00, 2'd1, 1'b1, 64'h10, 64'h1_0000_0003, 1'b0);
      // R3 upper half ignored, no sign extension
      run("R3 uword", 2'b01, 2'd0, 1'b1, 64'h20, 64'hDEAD_BEEF_8000_0005, 1'b0);
      // R4 negative word subtracts
      run("R4 sword neg", 2'b10, 2'd1, 1'b1, 64'h1000, 64'hABCD_0123_FFFF_FFFF, 1'b1);
      run("R4 sword pos", 2'b10, 2'd3, 1'b0, 64'h0, 64'hFFFF_FFFF_7FFF_FFFF, 1'b0);
      // R5 wrap: carry out and shifted-out bits dropped
      run("R5 carry", 2'b00, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0);
      run("R5 shift out", 2'b00, 2'd3, 1'b1, 64'h7, 64'hF000_0000_0000_0001, 1'b0);
      // R5 with R7: wrap to exactly zero
      run("R5 R7 wrap zero", 2'b00, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFF8, 64'h4, 1'b1);
      run("R4 R7 sword zero", 2'b10, 2'd2, 1'b1, 64'h40, 64'h0000_0000_FFFF_FFF8, 1'b0);
      // R8 no record
      run("R8 norec", 2'b01, 2'd2, 1'b0, 64'h3, 64'h9, 1'b1);
      // R9 illegal
      run("R9 illegal", 2'b11, 2'd1, 1'b1, 64'h1234, 64'h5, 1'b0);

      void'($urandom(32'd20240207));
      for (int i = 0; i < 400; i++) begin
         logic [63:0] b, x;
         logic [1:0]  op;
         b  = {$urandom(), $urandom()};
         x  = {$urandom(), $urandom()};
         op = 2'($urandom_range(0, 3));
         if (i % 7 == 0) b = -(x << 1);
         run("R2 R3 R4 R7 random", op, 2'($urandom_range(0, 3)), 1'($urandom()),
             b, x, 1'($urandom()));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule